// File: doc/BRIEF.md
# Two-Wire Debug Frame Master

This block drives a two-wire debug link toward a target device. One wire is a clock that only the master drives. The other is a data line that the master and the target take turns driving. The clock's low time carries the meaning. A short low pulse clocks one bit. A long low pulse resets the target. The block issues the reset pulse and four single-byte frames: write or read of the target's address register, and write or read of its data register.

A host starts an operation with a one-cycle request carrying a 3-bit operation code and a write byte. When the operation ends, the block returns a one-cycle acknowledge with an error flag and the last byte read. Each frame has the same shape:

- a START strobe with the line released;
- a 2-bit instruction code;
- for data frames, a length field and a WAIT field polled up to a retry limit;
- an 8-bit field;
- a STOP strobe.

All pulse widths are cycle counts derived from the system clock frequency parameter and nanosecond timing parameters.

Top module: `twd_master`

## Requirements
- R1: After reset the clock line value is 1 with its driver off, the data driver is off and acknowledge is 0. The clock driver enable follows `access_en_i` one cycle later, and the clock value is already 1 when the driver turns on.
- R2: Operation code 0 (target reset) holds the clock low for RST_LOW_NS (2500 cycles at default), then high for at least RST_IDLE_NS, and acknowledges without error. It is one pulse.
- R3: Every bit strobe holds the clock low for exactly STB_LOW_NS (100 cycles at default). A new data value is set up at least one system clock before the clock falls.
- R4: Every frame opens with a START strobe and closes with a STOP strobe. The data driver is off during both.
- R5: The two strobes after START drive the instruction code, least significant bit first: 11b for address write (op 1), 10b for address read (op 2), 01b for data write (op 3), 00b for data read (op 4).
- R6: Address write drives the 8-bit write byte, least significant bit first, on strobes 3 to 10. The frame has 12 strobes.
- R7: Address read releases the line on strobes 3 to 10. The value sampled after the first of these becomes bit 0 of the read byte. The frame has 12 strobes.
- R8: Data write drives a length field of two 0 bits, then the byte least significant bit first, then releases the line and polls WAIT strobes until the line reads 1, then sends STOP.
- R9: Data read drives two 0 length bits, then polls WAIT strobes until the line reads 1, then samples 8 data bits least significant bit first, then sends STOP.
- R10: If WAIT reads 0 on WAIT_RETRIES consecutive strobes (20 at default), the frame ends with no STOP, acknowledge with error set and the line released. A 1 on the last allowed strobe still succeeds.
- R11: A request made while access is disabled, or with an operation code above 4, is acknowledged with error and produces no strobe.
- R12: Acknowledge is a single-cycle pulse, and the error flag is 1 only together with acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| access_en_i | input | 1 | Enables the clock line driver and operations |
| req_i | input | 1 | One-cycle operation request, taken when idle |
| op_i | input | 3 | Operation: 0 reset, 1 addr write, 2 addr read, 3 data write, 4 data read |
| wdata_i | input | 8 | Byte sent by write operations |
| rdata_o | output | 8 | Byte returned by the last successful read |
| ack_o | output | 1 | Operation finished (one cycle) |
| err_o | output | 1 | Operation failed, valid with ack_o |
| ck_o | output | 1 | Clock line value |
| ck_oe_o | output | 1 | Clock line driver enable |
| dd_o | output | 1 | Data line value when driven |
| dd_oe_o | output | 1 | Data line driver enable |
| dd_i | input | 1 | Data line as seen at the pin |

## Verification
The hardest condition to create is the retry limit in the WAIT field. The target must hold the line low for exactly the allowed number of strobes, and then for one strobe more. The bench models the target as a per-strobe response pattern that it indexes on each falling clock edge. Frames with a long low WAIT run are built from that pattern: one answers on the final allowed strobe, one never answers. The bench then confirms from the strobe count that the failing frame sent no STOP.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int unsigned TWD_BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_ADDR_WR = 3'd1,
    OP_ADDR_RD = 3'd2,
    OP_DATA_WR = 3'd3,
    OP_DATA_RD = 3'd4
  } twd_op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RST, PH_START, PH_INS, PH_LEN, PH_DATA, PH_WAIT, PH_STOP
  } twd_phase_e;

  typedef enum logic [1:0] {SG_IDLE, SG_LOW, SG_HIGH} twd_sg_e;

  // instruction code, bit 0 goes on the wire first
  function automatic logic [1:0] ins_code(twd_op_e op);
    case (op)
      OP_ADDR_WR: ins_code = 2'b11;
      OP_ADDR_RD: ins_code = 2'b10;
      OP_DATA_WR: ins_code = 2'b01;
      default:    ins_code = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/twd_strobe_gen.sv
module twd_strobe_gen
  import twd_pkg::*;
#(
  parameter int unsigned STB_LOW_CYC  = 100,
  parameter int unsigned STB_HIGH_CYC = 100,
  parameter int unsigned RST_LOW_CYC  = 2500,
  parameter int unsigned RST_IDLE_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic ck_o,
  output logic done_o
);
  localparam int unsigned MAX_A   = (STB_LOW_CYC > STB_HIGH_CYC) ? STB_LOW_CYC : STB_HIGH_CYC;
  localparam int unsigned MAX_B   = (RST_LOW_CYC > RST_IDLE_CYC) ? RST_LOW_CYC : RST_IDLE_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  twd_sg_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          long_q;
  logic          ck_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SG_IDLE;
      cnt_q  <= '0;
      long_q <= 1'b0;
      ck_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SG_IDLE: if (start_i) begin
          st_q   <= SG_LOW;
          ck_q   <= 1'b0;
          long_q <= long_i;
          cnt_q  <= long_i ? CW'(RST_LOW_CYC - 1) : CW'(STB_LOW_CYC - 1);
        end
        SG_LOW: if (cnt_q == '0) begin
          st_q  <= SG_HIGH;
          ck_q  <= 1'b1;
          cnt_q <= long_q ? CW'(RST_IDLE_CYC - 1) : CW'(STB_HIGH_CYC - 1);
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        SG_HIGH: if (cnt_q == '0) begin
          st_q   <= SG_IDLE;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        default: st_q <= SG_IDLE;
      endcase
    end
  end

  assign ck_o   = ck_q;
  assign done_o = done_q;
endmodule

// File: rtl/twd_shift_reg.sv
module twd_shift_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // right shift, new bit enters at the MSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= load_val_i;
    else if (shift_i) q <= {bit_i, q[W-1:1]};
  end

  assign q_o = q;
endmodule

// File: rtl/twd_retry_ctr.sv
module twd_retry_ctr #(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned RW = $clog2(LIMIT + 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + RW'(1);
  end

  assign last_o = (cnt_q == RW'(LIMIT - 1));
endmodule

// File: rtl/twd_master.sv
module twd_master
  import twd_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned STB_LOW_NS   = 1000,
  parameter int unsigned STB_HIGH_NS  = 1000,
  parameter int unsigned RST_LOW_NS   = 25000,
  parameter int unsigned RST_IDLE_NS  = 1000,
  parameter int unsigned WAIT_RETRIES = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       access_en_i,
  input  logic       req_i,
  input  logic [2:0] op_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       ack_o,
  output logic       err_o,
  output logic       ck_o,
  output logic       ck_oe_o,
  output logic       dd_o,
  output logic       dd_oe_o,
  input  logic       dd_i
);
  localparam int unsigned CLK_MHZ      = CLK_HZ / 1_000_000;
  localparam int unsigned STB_LOW_CYC  = (CLK_MHZ * STB_LOW_NS  / 1000 > 0) ? CLK_MHZ * STB_LOW_NS  / 1000 : 1;
  localparam int unsigned STB_HIGH_CYC = (CLK_MHZ * STB_HIGH_NS / 1000 > 0) ? CLK_MHZ * STB_HIGH_NS / 1000 : 1;
  localparam int unsigned RST_LOW_CYC  = (CLK_MHZ * RST_LOW_NS  / 1000 > 0) ? CLK_MHZ * RST_LOW_NS  / 1000 : 1;
  localparam int unsigned RST_IDLE_CYC = (CLK_MHZ * RST_IDLE_NS / 1000 > 0) ? CLK_MHZ * RST_IDLE_NS / 1000 : 1;
  localparam int unsigned W            = TWD_BYTE_W;
  localparam int unsigned BW           = $clog2(W);

  twd_phase_e    phase_q, nxt_phase;
  twd_op_e       op_q;
  logic [BW-1:0] bit_q, nxt_bit;
  logic          drv_q, drv_oe_q, nxt_val, nxt_oe;
  logic          start_q, long_q, ack_q, err_q, ck_oe_q;
  logic [W-1:0]  rdata_q, sh_q;
  logic          strb_done, ck_w, retry_last;
  logic          fin, fin_err, busy, accept, op_ok;
  logic          is_addr, is_wr, is_rd;
  logic [1:0]    ins;

  assign busy    = (phase_q != PH_IDLE);
  assign accept  = req_i && !busy;
  assign op_ok   = access_en_i && (op_i <= 3'd4);
  assign is_addr = (op_q == OP_ADDR_WR) || (op_q == OP_ADDR_RD);
  assign is_wr   = (op_q == OP_ADDR_WR) || (op_q == OP_DATA_WR);
  assign is_rd   = (op_q == OP_ADDR_RD) || (op_q == OP_DATA_RD);
  assign ins     = ins_code(op_q);

  twd_strobe_gen #(
    .STB_LOW_CYC (STB_LOW_CYC),
    .STB_HIGH_CYC(STB_HIGH_CYC),
    .RST_LOW_CYC (RST_LOW_CYC),
    .RST_IDLE_CYC(RST_IDLE_CYC)
  ) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_q),
    .long_i (long_q),
    .ck_o   (ck_w),
    .done_o (strb_done)
  );

  twd_shift_reg #(.W(W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept && op_ok),
    .load_val_i(wdata_i),
    .shift_i   (strb_done && (phase_q == PH_DATA)),
    .bit_i     (dd_i),
    .q_o       (sh_q)
  );

  twd_retry_ctr #(.LIMIT(WAIT_RETRIES)) u_retry (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (accept),
    .inc_i (strb_done && (phase_q == PH_WAIT) && !dd_i && !retry_last),
    .last_o(retry_last)
  );

  // next field after the current strobe completes
  always_comb begin
    nxt_phase = phase_q;
    nxt_bit   = bit_q;
    fin       = 1'b0;
    fin_err   = 1'b0;
    case (phase_q)
      PH_START: begin nxt_phase = PH_INS; nxt_bit = '0; end
      PH_INS: begin
        if (bit_q == '0) nxt_bit = BW'(1);
        else begin
          nxt_phase = is_addr ? PH_DATA : PH_LEN;
          nxt_bit   = '0;
        end
      end
      PH_LEN: begin
        if (bit_q == '0) nxt_bit = BW'(1);
        else begin
          nxt_phase = (op_q == OP_DATA_WR) ? PH_DATA : PH_WAIT;
          nxt_bit   = '0;
        end
      end
      PH_DATA: begin
        if (bit_q != BW'(W - 1)) nxt_bit = bit_q + BW'(1);
        else nxt_phase = (op_q == OP_DATA_WR) ? PH_WAIT : PH_STOP;
      end
      PH_WAIT: begin
        if (dd_i) begin
          nxt_phase = (op_q == OP_DATA_WR) ? PH_STOP : PH_DATA;
          nxt_bit   = '0;
        end else if (retry_last) begin
          nxt_phase = PH_IDLE;
          fin       = 1'b1;
          fin_err   = 1'b1;
        end
      end
      PH_STOP, PH_RST: begin nxt_phase = PH_IDLE; fin = 1'b1; end
      default: nxt_phase = PH_IDLE;
    endcase
  end

  // line drive for the field about to be strobed
  always_comb begin
    nxt_oe  = 1'b0;
    nxt_val = 1'b0;
    case (nxt_phase)
      PH_INS:  begin nxt_oe = 1'b1; nxt_val = ins[nxt_bit[0]]; end
      PH_LEN:  begin nxt_oe = 1'b1; nxt_val = 1'b0; end
      PH_DATA: begin
        nxt_oe  = is_wr;
        nxt_val = is_wr && ((phase_q == PH_DATA) ? sh_q[1] : sh_q[0]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      op_q     <= OP_RESET;
      bit_q    <= '0;
      drv_q    <= 1'b0;
      drv_oe_q <= 1'b0;
      start_q  <= 1'b0;
      long_q   <= 1'b0;
      ack_q    <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
      ck_oe_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      ck_oe_q <= access_en_i;
      if (accept) begin
        if (!op_ok) begin
          ack_q <= 1'b1;
          err_q <= 1'b1;
        end else begin
          op_q     <= twd_op_e'(op_i);
          bit_q    <= '0;
          drv_oe_q <= 1'b0;
          start_q  <= 1'b1;
          long_q   <= (op_i == 3'd0);
          phase_q  <= (op_i == 3'd0) ? PH_RST : PH_START;
        end
      end else if (strb_done) begin
        if (fin) begin
          phase_q  <= PH_IDLE;
          drv_oe_q <= 1'b0;
          drv_q    <= 1'b0;
          ack_q    <= 1'b1;
          err_q    <= fin_err;
          if (is_rd && !fin_err) rdata_q <= sh_q;
        end else begin
          phase_q  <= nxt_phase;
          bit_q    <= nxt_bit;
          drv_oe_q <= nxt_oe;
          drv_q    <= nxt_val;
          start_q  <= 1'b1;
        end
      end
    end
  end

  assign rdata_o = rdata_q;
  assign ack_o   = ack_q;
  assign err_o   = err_q;
  assign ck_o    = ck_w;
  assign ck_oe_o = ck_oe_q;
  assign dd_o    = drv_q;
  assign dd_oe_o = drv_oe_q;
endmodule

// File: rtl/twd_master_chk.sv
module twd_master_chk #(
  parameter int unsigned STB_LOW_CYC = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ck_o,
  input logic ck_oe_o,
  input logic dd_o,
  input logic dd_oe_o,
  input logic ack_o,
  input logic err_o,
  input logic long_i,
  input logic busy_i
);
  localparam int unsigned LW = $clog2(STB_LOW_CYC + 2);

  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lo_cnt <= '0;
    else if (ck_o)                        lo_cnt <= '0;
    else if (lo_cnt <= LW'(STB_LOW_CYC))  lo_cnt <= lo_cnt + LW'(1);
  end

  // R3
  strobe_low_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!long_i && !ck_o) |-> (lo_cnt < LW'(STB_LOW_CYC)));

  // R3
  data_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ck_o) |-> ($stable(dd_o) && $stable(dd_oe_o)));

  // R1
  ck_high_at_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ck_oe_o) |-> ck_o);

  // R12
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R12
  err_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ack_o);

  // R4
  drive_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dd_oe_o |-> busy_i);
endmodule

bind twd_master twd_master_chk #(.STB_LOW_CYC(STB_LOW_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ck_o   (ck_o),
  .ck_oe_o(ck_oe_o),
  .dd_o   (dd_o),
  .dd_oe_o(dd_oe_o),
  .ack_o  (ack_o),
  .err_o  (err_o),
  .long_i (long_q),
  .busy_i (busy)
);

// File: tb/sim_twd_master.sv
`timescale 1ns/1ps
module sim_twd_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       access_en = 1'b0;
  logic       req = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ack, err, ck, ck_oe, dd, dd_oe, dd_in;
  logic       tgt_val = 1'b1;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned n_stb = 0;
  int unsigned lo_run = 0;
  int unsigned lo_min = 0;
  int unsigned lo_max = 0;
  logic [63:0] pat = '0;
  logic [63:0] oe_bits = '0;
  logic [63:0] val_bits = '0;
  logic        got_err;
  logic [7:0]  got_rd;

  always #5 clk = ~clk;

  assign dd_in = dd_oe ? dd : tgt_val;

  twd_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .access_en_i(access_en), .req_i(req),
    .op_i(op), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack), .err_o(err),
    .ck_o(ck), .ck_oe_o(ck_oe), .dd_o(dd), .dd_oe_o(dd_oe), .dd_i(dd_in)
  );

  // target model: one response bit per strobe, presented from the falling edge
  always @(negedge ck) begin
    if (ck_oe && n_stb < 64) begin
      oe_bits[n_stb]  = dd_oe;
      val_bits[n_stb] = dd & dd_oe;
      tgt_val         = pat[n_stb];
      n_stb           = n_stb + 1;
    end
  end

  always @(negedge clk) begin
    if (ck === 1'b0) lo_run = lo_run + 1;
    else if (lo_run != 0) begin
      if (lo_min == 0 || lo_run < lo_min) lo_min = lo_run;
      if (lo_run > lo_max) lo_max = lo_run;
      lo_run = 0;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [7:0] wd, input logic [63:0] p);
    @(negedge clk);
    pat = p; n_stb = 0; oe_bits = '0; val_bits = '0; lo_min = 0; lo_max = 0;
    op = o; wdata = wd; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (ack !== 1'b1) @(negedge clk);
    got_err = err;
    got_rd  = rdata;
    @(negedge clk);
    chk(ack == 1'b0, "R12 ack single cycle", {63'd0, ack}, 64'd0);
  endtask

  task automatic t_reset_state();
    chk(ck == 1'b1 && ck_oe == 1'b0 && dd_oe == 1'b0 && ack == 1'b0, "R1 reset state",
        {60'd0, ck, ck_oe, dd_oe, ack}, 64'h8);
    @(negedge clk); access_en = 1'b1;
    @(negedge clk);
    chk(ck_oe == 1'b1 && ck == 1'b1, "R1 clock driver enable", {62'd0, ck_oe, ck}, 64'h3);
  endtask

  task automatic t_target_reset();
    run_op(3'd0, 8'h00, '0);
    chk(n_stb == 1, "R2 single pulse", 64'(n_stb), 64'd1);
    chk(lo_max == 2500, "R2 reset low width", 64'(lo_max), 64'd2500);
    chk(got_err == 1'b0 && ck == 1'b1, "R2 ack no error", {62'd0, got_err, ck}, 64'h1);
  endtask

  task automatic t_addr_write();
    logic [63:0] eoe, ev;
    run_op(3'd1, 8'hB4, '0);
    eoe = 64'h7FE;
    ev  = 64'h6 | (64'hB4 << 3);
    chk(n_stb == 12, "R6 strobe count", 64'(n_stb), 64'd12);
    chk(oe_bits == eoe, "R4 R6 drive pattern", oe_bits, eoe);
    chk(val_bits == ev, "R5 R6 driven bits", val_bits, ev);
    chk(lo_min == 100 && lo_max == 100, "R3 strobe low width", {lo_min, lo_max}, {32'd100, 32'd100});
    chk(got_err == 1'b0, "R12 no error", 64'(got_err), 64'd0);
  endtask

  task automatic t_addr_read();
    logic [63:0] p;
    p = 64'h3C << 3;
    run_op(3'd2, 8'hFF, p);
    chk(n_stb == 12, "R7 strobe count", 64'(n_stb), 64'd12);
    chk(oe_bits == 64'h6 && val_bits == 64'h4, "R5 R7 code 10b released field",
        {oe_bits[31:0], val_bits[31:0]}, {32'h6, 32'h4});
    chk(got_rd == 8'h3C, "R7 read byte", 64'(got_rd), 64'h3C);
  endtask

  task automatic t_data_write();
    logic [63:0] p, ev;
    p = 64'd1 << 13;
    run_op(3'd3, 8'h5A, p);
    ev = 64'h2 | (64'h5A << 5);
    chk(n_stb == 15, "R8 strobe count", 64'(n_stb), 64'd15);
    chk(oe_bits == 64'h1FFE, "R4 R8 drive pattern", oe_bits, 64'h1FFE);
    chk(val_bits == ev, "R5 R8 driven bits", val_bits, ev);
    chk(got_err == 1'b0, "R8 no error", 64'(got_err), 64'd0);
  endtask

  task automatic t_data_read();
    logic [63:0] p;
    p = (64'd1 << 8) | (64'hA5 << 9);
    run_op(3'd4, 8'h00, p);
    chk(n_stb == 18, "R9 strobe count with 3 wait retries", 64'(n_stb), 64'd18);
    chk(oe_bits == 64'h1E && val_bits == 64'h0, "R5 R9 code and length",
        {oe_bits[31:0], val_bits[31:0]}, {32'h1E, 32'h0});
    chk(got_rd == 8'hA5 && got_err == 1'b0, "R9 read byte", {got_err, got_rd}, 9'h0A5);
  endtask

  task automatic t_wait_limit();
    run_op(3'd3, 8'h11, 64'd1 << 32);
    chk(n_stb == 34 && got_err == 1'b0, "R10 ready on last retry",
        {got_err, n_stb[31:0]}, 33'd34);
    run_op(3'd3, 8'h22, '0);
    chk(got_err == 1'b1, "R10 timeout error", 64'(got_err), 64'd1);
    chk(dd_oe == 1'b0, "R10 line released", 64'(dd_oe), 64'd0);
    repeat (500) @(negedge clk);
    chk(n_stb == 33, "R10 no stop strobe", 64'(n_stb), 64'd33);
  endtask

  task automatic t_rejects();
    run_op(3'd7, 8'h00, '0);
    chk(got_err == 1'b1 && n_stb == 0, "R11 undefined op", {got_err, n_stb[31:0]}, {1'b1, 32'd0});
    access_en = 1'b0;
    run_op(3'd1, 8'h55, '0);
    chk(got_err == 1'b1 && n_stb == 0, "R11 access disabled", {got_err, n_stb[31:0]}, {1'b1, 32'd0});
    chk(got_rd == 8'hA5, "R7 rdata kept by non-read ops", 64'(got_rd), 64'hA5);
    access_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_target_reset();
    t_addr_write();
    t_addr_read();
    t_data_write();
    t_data_read();
    t_wait_limit();
    t_rejects();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule